// File: doc/BRIEF.md
# Flash output and power mode controller

This block decides, cycle by cycle, whether a parallel flash device drives its data pins and which power mode it is in. It watches the chip-enable, output-enable and hardware-reset pins, the address bus, and a busy flag raised by the command sequencer while a program or erase runs. From these it produces a drive-enable for the data pins, a data latch that holds the most recently read array word, a flag that marks the latch as valid, and a 2-bit power-state code.

Address stability is measured in clock cycles. Each change of the address bus restarts both an access timer, which latches fresh array data once the access time has passed, and a stability counter. Once the address has stayed put for the access time plus a margin, the device drops into automatic sleep, where it keeps the latched word on the pins for as long as the address does not move. Power states are reported as: 0 active, 1 standby, 2 automatic sleep, 3 reset.

The data pins are plain control and data signals and not a stream, so there is no handshake and no back-pressure. The pins of a flash device have no way to stall the host. A reader must wait for `data_valid` or keep to the access time.

Top module: `flash_pm_ctrl`

## Requirements
- R1: While `rst_n` is low, `pwr_state` is 3, `dout_oe` is 0, `data_valid` is 0 and `dout` is 0.
- R2: With `dev_rst_n` low, `dout_oe` is 0 at once, and after the next clock edge `pwr_state` is 3 and `data_valid` is 0. Any command in progress (busy) is overridden.
- R3: With `oe_n` high, `dout_oe` is 0 in the same cycle, in every power state.
- R4: With `ce_n` high and `busy` low, `pwr_state` becomes 1 (standby) at the next edge, and `dout_oe` stays 0 whatever `oe_n` is.
- R5: With `busy` high and `dev_rst_n` high, `pwr_state` is 0 (active) after the next edge, even with `ce_n` high.
- R6: After the address bus changes, `data_valid` is 0 from the first edge. The array word for the new address appears on `dout`, with `data_valid` 1, exactly ACC_CYC+1 edges after the change.
- R7: When `ce_n` falls (leaving standby) or `dev_rst_n` rises, with the address held, `data_valid` turns 1 after exactly ACC_CYC edges and `dout` holds the current array word.
- R8: Automatic sleep (`pwr_state` 2) is entered on edge ACC_CYC+MARGIN_CYC+2 after an address change, counting the change edge as the first. It requires `ce_n` low, `busy` low and `data_valid` 1. While `busy` is high, sleep is not entered.
- R9: In sleep, `dout` does not change even if the array word behind it changes, and `dout_oe` follows the pins as in R11.
- R10: Sleep does not depend on `oe_n`, which may toggle without leaving sleep. Any address change returns `pwr_state` to 0 after one edge.
- R11: `dout_oe` is 1 exactly when `pwr_state` is 0 or 2, `ce_n` is low, `oe_n` is low and `dev_rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous block reset, active low |
| dev_rst_n | input | 1 | Device hardware-reset pin, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Program or erase in progress, from the command sequencer |
| addr | input | AW | Address bus |
| array_data | input | DW | Array word at the current address |
| dout | output | DW | Latched read data |
| dout_oe | output | 1 | Data pin driver enable |
| data_valid | output | 1 | Latched data belongs to the current address |
| pwr_state | output | 2 | 0 active, 1 standby, 2 sleep, 3 reset |

## Verification
The hardest state to reach is sleep with its latched word under test. The bench must hold the address still for more than the full stability window, keep chip enable low and busy low, and only then disturb things. It does this by changing the array word behind the latch, toggling output enable, and finally moving the address. Edge counts are taken from the address change, so the one-cycle boundaries of entry to sleep and of data validity are both checked. Busy is held over a window longer than the threshold to show that sleep stays blocked.

// File: rtl/flash_pm_pkg.sv
package flash_pm_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_STANDBY = 2'd1,
    PS_SLEEP   = 2'd2,
    PS_RESET   = 2'd3
  } pwr_t;

endpackage

// File: rtl/flash_addr_watch.sv
module flash_addr_watch #(
  parameter int AW  = 20,
  parameter int THR = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [AW-1:0] addr,
  output logic          addr_chg,
  output logic          stable_hit
);
  localparam int CW = $clog2(THR + 1);
  localparam logic [CW-1:0] THR_C = CW'(THR);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt;

  assign addr_chg   = (addr != addr_q);
  assign stable_hit = (cnt == THR_C);

  // counter restarts on any address move and saturates at the threshold
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt    <= '0;
    end else begin
      addr_q <= addr;
      if (clr || addr_chg)   cnt <= '0;
      else if (!stable_hit)  cnt <= cnt + CW'(1);
    end
  end

  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= THR_C);  // R8
  AST_MOVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_chg |=> !stable_hit);  // R10

endmodule

// File: rtl/flash_access_timer.sv
module flash_access_timer #(
  parameter int DW  = 16,
  parameter int ACC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] dout,
  output logic          valid
);
  localparam int CW = (ACC > 1) ? $clog2(ACC) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      dout  <= '0;
      valid <= 1'b0;
    end else if (restart) begin
      cnt   <= '0;
      valid <= 1'b0;
    end else if (!valid) begin
      if (cnt == LAST) begin
        dout  <= array_data;
        valid <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  AST_RESTART_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !valid);  // R6
  AST_VALID_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !restart) |=> $stable(dout));  // R9

endmodule

// File: rtl/flash_power_fsm.sv
module flash_power_fsm
  import flash_pm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dev_rst_n,
  input  logic ce_n,
  input  logic busy,
  input  logic stable_hit,
  input  logic addr_chg,
  input  logic data_valid,
  output pwr_t state
);
  pwr_t nxt;

  // reset pin wins, then a running operation keeps the part active,
  // then deselect gives standby, then a settled address gives sleep
  always_comb begin
    if (!dev_rst_n)                                  nxt = PS_RESET;
    else if (busy)                                   nxt = PS_ACTIVE;
    else if (ce_n)                                   nxt = PS_STANDBY;
    else if (stable_hit && !addr_chg && data_valid)  nxt = PS_SLEEP;
    else                                             nxt = PS_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PS_RESET;
    else        state <= nxt;
  end

  AST_RESET_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n |=> state == PS_RESET);  // R2
  AST_BUSY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rst_n && busy) |=> state == PS_ACTIVE);  // R5
  AST_SLEEP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    state == PS_SLEEP |-> data_valid);  // R8

endmodule

// File: rtl/flash_pm_ctrl.sv
module flash_pm_ctrl
  import flash_pm_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 20,
  parameter int ACC_CYC    = 4,
  parameter int MARGIN_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          busy,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          data_valid,
  output logic [1:0]    pwr_state
);
  localparam int SLEEP_CYC = ACC_CYC + MARGIN_CYC;

  logic addr_chg, stable_hit, restart;
  pwr_t state;

  assign restart = addr_chg || ce_n || !dev_rst_n;

  flash_addr_watch #(.AW(AW), .THR(SLEEP_CYC)) u_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (!dev_rst_n),
    .addr       (addr),
    .addr_chg   (addr_chg),
    .stable_hit (stable_hit)
  );

  flash_access_timer #(.DW(DW), .ACC(ACC_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .array_data (array_data),
    .dout       (dout),
    .valid      (data_valid)
  );

  flash_power_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_rst_n  (dev_rst_n),
    .ce_n       (ce_n),
    .busy       (busy),
    .stable_hit (stable_hit),
    .addr_chg   (addr_chg),
    .data_valid (data_valid),
    .state      (state)
  );

  assign pwr_state = state;
  assign dout_oe   = ((state == PS_ACTIVE) || (state == PS_SLEEP))
                     && !ce_n && !oe_n && dev_rst_n;

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_oe);  // R3
  AST_STANDBY_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
    state == PS_STANDBY |-> !dout_oe);  // R4
  AST_RESET_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n |-> !dout_oe);  // R2
  AST_SLEEP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    state == PS_SLEEP |=> $stable(dout));  // R9

endmodule

// File: tb/flash_pm_ctrl_test.sv
`timescale 1ns/1ps
module flash_pm_ctrl_test;
  localparam int DW = 16, AW = 20, ACC = 4, MRG = 6;
  localparam int THR = ACC + MRG;

  logic clk = 1'b0, rst_n = 1'b0, dev_rst_n = 1'b1, ce_n = 1'b1, oe_n = 1'b0, busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] array_data, dout;
  logic [7:0] mask = 8'h00;
  logic dout_oe, data_valid;
  logic [1:0] pwr_state;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] word_of(logic [AW-1:0] a, logic [7:0] m);
    return {a[7:0] ^ m, ~a[7:0]};
  endfunction
  assign array_data = word_of(addr, mask);

  flash_pm_ctrl #(.DW(DW), .AW(AW), .ACC_CYC(ACC), .MARGIN_CYC(MRG)) uut (
    .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .busy(busy), .addr(addr), .array_data(array_data), .dout(dout),
    .dout_oe(dout_oe), .data_valid(data_valid), .pwr_state(pwr_state));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic ce; logic oe; logic bz; logic drst;
    logic [7:0] a; logic [7:0] cyc; logic [1:0] st; logic drv;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'h05, 8'd12, 2'd1, 1'b0},  // R4 standby
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'h05, 8'd3,  2'd0, 1'b1},  // R11 active read
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'h05, 8'd1,  2'd0, 1'b0},  // R3 output disable
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'h05, 8'd2,  2'd2, 1'b1},  // R9 sleep drives
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'h09, 8'd1,  2'd0, 1'b1},  // R10 wake on move
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'h09, 8'd3,  2'd0, 1'b0},  // R5 busy deselected
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'h09, 8'd2,  2'd1, 1'b0},  // R4 standby again
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'h09, 8'd2,  2'd3, 1'b0},  // R2 reset pin
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'h09, 8'd2,  2'd0, 1'b1}   // R11 after reset
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    check("R1 state", 32'(pwr_state), 32'd3);
    check("R1 oe", 32'(dout_oe), 32'd0);
    check("R1 valid", 32'(data_valid), 32'd0);
    check("R1 dout", 32'(dout), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      ce_n = TBL[i].ce; oe_n = TBL[i].oe; busy = TBL[i].bz;
      dev_rst_n = TBL[i].drst; addr = {12'h0, TBL[i].a};
      tick(int'(TBL[i].cyc));
      check($sformatf("vec%0d state", i), 32'(pwr_state), 32'(TBL[i].st));
      check($sformatf("vec%0d oe", i), 32'(dout_oe), 32'(TBL[i].drv));
    end

    // R6 exact data timing after an address move
    addr = 20'h00021;
    tick(1);
    check("R6 valid drop", 32'(data_valid), 32'd0);
    tick(ACC - 1);
    check("R6 not yet", 32'(data_valid), 32'd0);
    tick(1);
    check("R6 valid", 32'(data_valid), 32'd1);
    check("R6 data", 32'(dout), 32'(word_of(20'h00021, mask)));

    // R8 exact sleep boundary: THR+1 edges active, THR+2 sleep
    tick(THR - ACC);
    check("R8 still active", 32'(pwr_state), 32'd0);
    tick(1);
    check("R8 sleep", 32'(pwr_state), 32'd2);
    check("R9 drives in sleep", 32'(dout_oe), 32'd1);

    // R9 latch holds while array changes; R10 oe toggle does not wake
    mask = 8'h5A;
    oe_n = 1'b1;
    tick(3);
    check("R10 oe toggle stays asleep", 32'(pwr_state), 32'd2);
    check("R3 oe off in sleep", 32'(dout_oe), 32'd0);
    check("R9 held data", 32'(dout), 32'(word_of(20'h00021, 8'h00)));
    oe_n = 1'b0;
    tick(1);
    check("R9 drive back", 32'(dout_oe), 32'd1);
    check("R9 held data 2", 32'(dout), 32'(word_of(20'h00021, 8'h00)));

    // R10 address move exits sleep after one edge
    addr = 20'h00022;
    tick(1);
    check("R10 wake", 32'(pwr_state), 32'd0);

    // R8 busy blocks sleep
    busy = 1'b1;
    tick(THR + 10);
    check("R8 busy blocks sleep", 32'(pwr_state), 32'd0);
    busy = 1'b0;
    tick(1);
    check("R8 sleep after busy", 32'(pwr_state), 32'd2);

    // R7 wake from standby
    ce_n = 1'b1;
    tick(3);
    check("R4 standby", 32'(pwr_state), 32'd1);
    check("R7 valid cleared", 32'(data_valid), 32'd0);
    ce_n = 1'b0;
    tick(ACC - 1);
    check("R7 not yet", 32'(data_valid), 32'd0);
    tick(1);
    check("R7 valid", 32'(data_valid), 32'd1);
    check("R7 data", 32'(dout), 32'(word_of(20'h00022, mask)));

    // R2 reset pin overrides busy and clears data
    busy = 1'b1; dev_rst_n = 1'b0;
    @(negedge clk);
    check("R2 oe immediate", 32'(dout_oe), 32'd0);
    tick(1);
    check("R2 state", 32'(pwr_state), 32'd3);
    check("R2 valid", 32'(data_valid), 32'd0);
    busy = 1'b0; dev_rst_n = 1'b1;
    tick(ACC);
    check("R7 after reset pin", 32'(data_valid), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule